// File: doc/BRIEF.md
# PCI Bus Handshake Protocol Monitor

This block watches the control lines of a PCI bus without driving any of them. On every rising clock edge it samples the cycle-frame, initiator-ready, target-ready, stop and device-select lines and the command/byte-enable nibble. All of these are active low. From those samples it works out which bus phase was just seen: idle, address, data or turnaround. In each address phase it decodes the command and holds it. It counts the data transfers that complete and reports an address phase that follows the last data phase with no idle cycle between them.

Its main job is to catch broken handshakes. The monitor keeps a separate sticky flag for each of these faults:
- an initiator that changes its lines after it has committed to a data phase;
- a target that changes its lines after it has committed to a data phase;
- an initiator that releases the cycle-frame line without being ready;
- an address phase that carries a reserved command.

A flag stays set until a synchronous clear pulse. All outputs are registered and show the classification of the most recent sampled edge. An asynchronous active-low reset returns the monitor to idle.

Top module: `pci_handshake_monitor`

## Requirements
- R1: While reset is held and right after its release, `phase` is 0 (idle), `cmd` is 7 (none), `xfer_cnt` is 0, `fb2b` is 0 and all four error flags are 0.
- R2: Phase codes are 0 idle, 1 address, 2 data and 3 turnaround. A sample with FRAME# asserted, taken after an idle or turnaround sample, is an address phase. The sample after an address phase is always a data phase.
- R3: In an address phase the raw C/BE[3:0] nibble selects `cmd`: 0000 gives 0 (interrupt acknowledge), 0001 gives 1 (special cycle), 0010 gives 2 (I/O read), 0011 gives 3 (I/O write), 0110 gives 4 (memory read) and 0111 gives 5 (memory write). `cmd` holds its value until the next address phase.
- R4: Nibbles 0100, 0101, 1000 and 1001 give `cmd` 6 and set `err_rsvd_cmd`. Any other unlisted nibble gives `cmd` 7 and sets no flag.
- R5: `xfer_cnt` becomes 0 in every address phase. It rises by one for each data-phase sample with IRDY# and TRDY# both asserted, and it does not change otherwise.
- R6: A data-phase sample with IRDY# or TRDY# negated is a wait state. It leaves the count unchanged and raises no error.
- R7: A data phase ends on a sample with IRDY# asserted and either TRDY# or STOP# asserted. Suppose the previous sample was in a data phase, had IRDY# asserted and did not end it. If the current sample is also in a data phase and IRDY# or FRAME# has changed, `err_init_commit` is set.
- R8: Suppose the previous sample was in a data phase, had TRDY# or STOP# asserted and did not end it. If the current sample is also in a data phase and any of DEVSEL#, TRDY# or STOP# has changed, `err_tgt_commit` is set.
- R9: A data-phase sample with FRAME# and IRDY# both negated sets `err_frame_early`. The following sample ends the transaction: it is an address phase (not fast back-to-back) if FRAME# is asserted, otherwise a turnaround.
- R10: If a data phase ends with FRAME# negated, it was the final one. If the next sample has FRAME# negated it is a turnaround, and an idle sample follows unless FRAME# is asserted.
- R11: If the sample after a final data phase has FRAME# asserted, it is an address phase and `fb2b` is 1 for that sample only.
- R12: The error flags are sticky. A sample taken with `clr_err` high clears every flag, except that a fault detected in that same sample still sets its flag.
- R13: A data phase that ends by STOP# rather than TRDY# is not counted. After it, the initiator and target lines may change without raising a commit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the monitor |
| clr_err | input | 1 | Synchronous clear of all sticky error flags |
| frame_n | input | 1 | Cycle-frame line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| stop_n | input | 1 | Target stop line, active low |
| devsel_n | input | 1 | Device-select line, active low |
| cbe_n | input | 4 | Command / byte-enable nibble as seen on the bus |
| phase | output | 2 | Phase of the last sample: 0 idle, 1 address, 2 data, 3 turnaround |
| cmd | output | 3 | Decoded command of the latest address phase |
| xfer_cnt | output | CNT_W (16) | Completed transfers since the latest address phase |
| fb2b | output | 1 | High for a fast back-to-back address phase |
| err_init_commit | output | 1 | Sticky: initiator broke its commitment |
| err_tgt_commit | output | 1 | Sticky: target broke its commitment |
| err_frame_early | output | 1 | Sticky: FRAME# released while IRDY# negated |
| err_rsvd_cmd | output | 1 | Sticky: reserved command seen |

## Verification
Every output is registered, so a wrong phase classification appears on `phase` at the very sample where it happens. A wrong classification also leaves the next sample's behaviour out of line with R2, R10 or R11, so it shows up within one more cycle: a missing turnaround, a spurious fast back-to-back pulse, or a count that is not cleared. A stale copy of the previous sample shows up as a commit flag that rises when it should not, or stays low when it should rise, one cycle after the offending change. The count is compared on every cycle, so an increment on a wait state or a STOP# ending is caught in the cycle it happens.

// File: rtl/pcimon_pkg.sv
package pcimon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_TURN = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        CMD_INTACK  = 3'd0,
        CMD_SPECIAL = 3'd1,
        CMD_IORD    = 3'd2,
        CMD_IOWR    = 3'd3,
        CMD_MEMRD   = 3'd4,
        CMD_MEMWR   = 3'd5,
        CMD_RSVD    = 3'd6,
        CMD_NONE    = 3'd7
    } cmd_e;

    // control lines, 1 = asserted (inverted from bus level)
    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic devsel;
    } ctl_s;

    localparam int ERR_W     = 4;
    localparam int ERR_INIT  = 0;
    localparam int ERR_TGT   = 1;
    localparam int ERR_FRAME = 2;
    localparam int ERR_RSVD  = 3;

endpackage

// File: rtl/pcimon_cmd_decode.sv
module pcimon_cmd_decode
    import pcimon_pkg::*;
(
    input  logic [3:0] nib,
    output cmd_e       cmd,
    output logic       rsvd
);

    always_comb begin
        rsvd = 1'b0;
        case (nib)
            4'b0000: cmd = CMD_INTACK;
            4'b0001: cmd = CMD_SPECIAL;
            4'b0010: cmd = CMD_IORD;
            4'b0011: cmd = CMD_IOWR;
            4'b0110: cmd = CMD_MEMRD;
            4'b0111: cmd = CMD_MEMWR;
            4'b0100, 4'b0101, 4'b1000, 4'b1001: begin
                cmd  = CMD_RSVD;
                rsvd = 1'b1;
            end
            default: cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/pcimon_phase_track.sv
module pcimon_phase_track
    import pcimon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctl_s   cur,
    output phase_e ph_d,
    output phase_e ph_q,
    output ctl_s   prv_q,
    output logic   prv_end,
    output logic   fb2b_d
);

    typedef struct packed {
        phase_e ph;
        ctl_s   smp;
    } trk_s;

    trk_s st_d, st_q;
    logic prv_over;

    always_comb begin
        // previous sample closed its data phase
        prv_end  = st_q.smp.irdy & (st_q.smp.trdy | st_q.smp.stop);
        // previous sample ended the transaction (final transfer or abandon)
        prv_over = ~st_q.smp.frame & (prv_end | ~st_q.smp.irdy);
        fb2b_d   = 1'b0;
        st_d.smp = cur;
        case (st_q.ph)
            PH_ADDR: st_d.ph = PH_DATA;
            PH_DATA: begin
                if (prv_over) begin
                    st_d.ph = cur.frame ? PH_ADDR : PH_TURN;
                    fb2b_d  = cur.frame & prv_end;
                end else begin
                    st_d.ph = PH_DATA;
                end
            end
            default: st_d.ph = cur.frame ? PH_ADDR : PH_IDLE;
        endcase
        ph_d = st_d.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.smp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_q  = st_q.ph;
    assign prv_q = st_q.smp;

    // R2
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_ADDR |=> st_q.ph == PH_DATA);

    // R10
    turn_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_TURN |-> $past(st_q.ph) == PH_DATA);

endmodule

// File: rtl/pcimon_commit_chk.sv
module pcimon_commit_chk
    import pcimon_pkg::*;
(
    input  ctl_s   cur,
    input  ctl_s   prv,
    input  phase_e ph_q,
    input  phase_e ph_d,
    input  logic   prv_end,
    output logic   v_init,
    output logic   v_tgt,
    output logic   v_frame
);

    logic cont;
    logic tgt_held;

    always_comb begin
        // same data phase still open across both samples
        cont     = (ph_q == PH_DATA) & (ph_d == PH_DATA) & ~prv_end;
        tgt_held = prv.trdy | prv.stop;
        v_init   = cont & prv.irdy &
                   ((cur.irdy != prv.irdy) | (cur.frame != prv.frame));
        v_tgt    = cont & tgt_held &
                   ((cur.devsel != prv.devsel) | (cur.trdy != prv.trdy) |
                    (cur.stop != prv.stop));
        v_frame  = (ph_d == PH_DATA) & ~cur.frame & ~cur.irdy;
    end

endmodule

// File: rtl/pci_handshake_monitor.sv
module pci_handshake_monitor
    import pcimon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_err,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             devsel_n,
    input  logic [3:0]       cbe_n,
    output logic [1:0]       phase,
    output logic [2:0]       cmd,
    output logic [CNT_W-1:0] xfer_cnt,
    output logic             fb2b,
    output logic             err_init_commit,
    output logic             err_tgt_commit,
    output logic             err_frame_early,
    output logic             err_rsvd_cmd
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        cmd_e             cmd;
        logic [CNT_W-1:0] cnt;
        logic [ERR_W-1:0] err;
        logic             fb2b;
    } mon_s;

    ctl_s   cur;
    ctl_s   prv_q;
    phase_e ph_d, ph_q;
    logic   prv_end, fb2b_d;
    logic   v_init, v_tgt, v_frame;
    cmd_e   dec_cmd;
    logic   dec_rsvd;
    mon_s   m_d, m_q;
    logic [ERR_W-1:0] err_new;

    assign cur = '{frame: ~frame_n, irdy: ~irdy_n, trdy: ~trdy_n,
                   stop: ~stop_n, devsel: ~devsel_n};

    pcimon_phase_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (cur),
        .ph_d    (ph_d),
        .ph_q    (ph_q),
        .prv_q   (prv_q),
        .prv_end (prv_end),
        .fb2b_d  (fb2b_d)
    );

    pcimon_commit_chk u_commit (
        .cur     (cur),
        .prv     (prv_q),
        .ph_q    (ph_q),
        .ph_d    (ph_d),
        .prv_end (prv_end),
        .v_init  (v_init),
        .v_tgt   (v_tgt),
        .v_frame (v_frame)
    );

    pcimon_cmd_decode u_dec (
        .nib  (cbe_n),
        .cmd  (dec_cmd),
        .rsvd (dec_rsvd)
    );

    always_comb begin
        err_new            = '0;
        err_new[ERR_INIT]  = v_init;
        err_new[ERR_TGT]   = v_tgt;
        err_new[ERR_FRAME] = v_frame;
        err_new[ERR_RSVD]  = (ph_d == PH_ADDR) & dec_rsvd;

        m_d      = m_q;
        m_d.fb2b = fb2b_d;
        m_d.err  = (clr_err ? '0 : m_q.err) | err_new;
        if (ph_d == PH_ADDR) begin
            m_d.cmd = dec_cmd;
            m_d.cnt = '0;
        end else if (ph_d == PH_DATA && cur.irdy && cur.trdy) begin
            m_d.cnt = m_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.cmd  <= CMD_NONE;
            m_q.cnt  <= '0;
            m_q.err  <= '0;
            m_q.fb2b <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign phase           = ph_q;
    assign cmd             = m_q.cmd;
    assign xfer_cnt        = m_q.cnt;
    assign fb2b            = m_q.fb2b;
    assign err_init_commit = m_q.err[ERR_INIT];
    assign err_tgt_commit  = m_q.err[ERR_TGT];
    assign err_frame_early = m_q.err[ERR_FRAME];
    assign err_rsvd_cmd    = m_q.err[ERR_RSVD];

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_ADDR |-> m_q.cnt == '0);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_DATA |-> (m_q.cnt == $past(m_q.cnt) ||
                             m_q.cnt == $past(m_q.cnt) + CNT_ONE));

    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE || ph_q == PH_TURN) |-> $stable(m_q.cnt));

    // R11
    fb2b_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.fb2b |-> ph_q == PH_ADDR);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> ((m_q.err & $past(m_q.err)) == $past(m_q.err)));

endmodule

// File: tb/pci_handshake_monitor_bench.sv
`timescale 1ns/1ps
module pci_handshake_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_err = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        stop_n = 1'b1, devsel_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [1:0]  phase;
    logic [2:0]  cmd;
    logic [15:0] xfer_cnt;
    logic        fb2b;
    logic        e_init, e_tgt, e_frame, e_rsvd;

    int total = 0;
    int bad = 0;
    bit drv_done = 1'b0;

    typedef struct {
        logic [1:0]  ph;
        logic [2:0]  cm;
        logic [15:0] cn;
        logic [3:0]  er;
        logic        fb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pci_handshake_monitor #(.CNT_W(16)) u_pci_handshake_monitor (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .devsel_n(devsel_n), .cbe_n(cbe_n),
        .phase(phase), .cmd(cmd), .xfer_cnt(xfer_cnt), .fb2b(fb2b),
        .err_init_commit(e_init), .err_tgt_commit(e_tgt),
        .err_frame_early(e_frame), .err_rsvd_cmd(e_rsvd)
    );

    function automatic logic [3:0] errs();
        return {e_rsvd, e_frame, e_tgt, e_init};
    endfunction

    // driver: one bus cycle plus its expected outcome (asserted = 1 on f,i,t,s,d)
    task automatic step(input logic f, input logic i, input logic t,
                        input logic s, input logic d, input logic [3:0] cb,
                        input logic clr, input logic [1:0] ph,
                        input logic [2:0] cm, input logic [15:0] cn,
                        input logic [3:0] er, input logic fb, input string tag);
        exp_t it;
        @(negedge clk);
        frame_n = ~f; irdy_n = ~i; trdy_n = ~t; stop_n = ~s; devsel_n = ~d;
        cbe_n = cb; clr_err = clr;
        it.ph = ph; it.cm = cm; it.cn = cn; it.er = er; it.fb = fb; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // one short transaction: address, single final transfer, turnaround
    task automatic short_txn(input logic [3:0] cb, input logic [2:0] cm,
                             input logic [3:0] er, input string tag);
        step(1,0,0,0,0, cb,    0, 2'd1, cm, 16'd0, er, 0, tag);
        step(0,1,1,0,1, 4'h0,  0, 2'd2, cm, 16'd1, er, 0, tag);
        step(0,0,0,0,0, 4'hF,  0, 2'd3, cm, 16'd1, er, 0, tag);
    endtask

    // monitor: compare after each sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t it;
                it = exp_q.pop_front();
                total++;
                if (phase !== it.ph || cmd !== it.cm || xfer_cnt !== it.cn ||
                    errs() !== it.er || fb2b !== it.fb) begin
                    bad++;
                    $display("FAIL %s: got ph=%0d cmd=%0d cnt=%0d err=%b fb2b=%b exp ph=%0d cmd=%0d cnt=%0d err=%b fb2b=%b",
                             it.tag, phase, cmd, xfer_cnt, errs(), fb2b,
                             it.ph, it.cm, it.cn, it.er, it.fb);
                end
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        total++;
        if (phase !== 2'd0 || cmd !== 3'd7 || xfer_cnt !== 16'd0 ||
            errs() !== 4'b0 || fb2b !== 1'b0) begin
            bad++;
            $display("FAIL R1: got ph=%0d cmd=%0d cnt=%0d err=%b exp ph=0 cmd=7 cnt=0 err=0000",
                     phase, cmd, xfer_cnt, errs());
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,0, 4'hF, 0, 2'd0, 3'd7, 16'd0, 4'b0, 0, "R1 after release");

        // R2 R5 R6 R10: burst with waits
        step(1,0,0,0,0, 4'b0110, 0, 2'd1, 3'd4, 16'd0, 4'b0, 0, "R2 addr");
        step(1,1,0,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd0, 4'b0, 0, "R6 target wait");
        step(1,1,1,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd1, 4'b0, 0, "R5 first xfer");
        step(1,0,0,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd1, 4'b0, 0, "R6 initiator wait");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd2, 4'b0, 0, "R5 final xfer");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd4, 16'd2, 4'b0, 0, "R10 turnaround");
        step(0,0,0,0,0, 4'hF,    0, 2'd0, 3'd4, 16'd2, 4'b0, 0, "R10 idle");

        // R3: command encodings
        short_txn(4'b0000, 3'd0, 4'b0, "R3 intack");
        short_txn(4'b0001, 3'd1, 4'b0, "R3 special");
        short_txn(4'b0010, 3'd2, 4'b0, "R3 io read");
        short_txn(4'b0011, 3'd3, 4'b0, "R3 io write");
        short_txn(4'b0111, 3'd5, 4'b0, "R3 mem write");

        // R4: reserved and unlisted codes; R12 stickiness then clear
        short_txn(4'b1001, 3'd6, 4'b1000, "R4 reserved 1001");
        short_txn(4'b1010, 3'd7, 4'b1000, "R4 unlisted 1010 R12 sticky");
        step(0,0,0,0,0, 4'hF, 1, 2'd0, 3'd7, 16'd1, 4'b0000, 0, "R12 clear");
        short_txn(4'b0101, 3'd6, 4'b1000, "R4 reserved 0101");
        step(0,0,0,0,0, 4'hF, 1, 2'd0, 3'd6, 16'd1, 4'b0000, 0, "R12 clear");

        // R7: initiator drops FRAME# while committed
        step(1,0,0,0,0, 4'b0110, 0, 2'd1, 3'd4, 16'd0, 4'b0000, 0, "R7 addr");
        step(1,1,0,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd0, 4'b0000, 0, "R7 committed");
        step(0,1,0,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd0, 4'b0001, 0, "R7 frame change");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd1, 4'b0001, 0, "R7 complete");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd4, 16'd1, 4'b0001, 0, "R7 turn");

        // R8: target withdraws TRDY# while committed
        step(1,0,0,0,0, 4'b0111, 0, 2'd1, 3'd5, 16'd0, 4'b0001, 0, "R8 addr");
        step(1,0,1,0,1, 4'h0,    0, 2'd2, 3'd5, 16'd0, 4'b0001, 0, "R8 committed");
        step(1,0,0,0,1, 4'h0,    0, 2'd2, 3'd5, 16'd0, 4'b0011, 0, "R8 trdy change");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd5, 16'd1, 4'b0011, 0, "R8 complete");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd5, 16'd1, 4'b0011, 0, "R8 turn");

        // R9 with R12: violation in the clear cycle keeps its own flag
        step(1,0,0,0,0, 4'b0010, 0, 2'd1, 3'd2, 16'd0, 4'b0011, 0, "R9 addr");
        step(0,0,0,0,1, 4'h0,    1, 2'd2, 3'd2, 16'd0, 4'b0100, 0, "R9 early frame R12 set wins");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd2, 16'd0, 4'b0100, 0, "R9 ends");
        step(0,0,0,0,0, 4'hF,    1, 2'd0, 3'd2, 16'd0, 4'b0000, 0, "R12 clear");

        // R11: fast back-to-back
        step(1,0,0,0,0, 4'b0111, 0, 2'd1, 3'd5, 16'd0, 4'b0, 0, "R11 addr");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd5, 16'd1, 4'b0, 0, "R11 final");
        step(1,0,0,0,0, 4'b0010, 0, 2'd1, 3'd2, 16'd0, 4'b0, 1, "R11 fb2b addr");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd2, 16'd1, 4'b0, 0, "R11 pulse ends");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd2, 16'd1, 4'b0, 0, "R11 turn");
        step(0,0,0,0,0, 4'hF,    0, 2'd0, 3'd2, 16'd1, 4'b0, 0, "R11 idle");

        // R13: STOP# ends a data phase without a count
        step(1,0,0,0,0, 4'b0110, 0, 2'd1, 3'd4, 16'd0, 4'b0, 0, "R13 addr");
        step(1,1,0,1,1, 4'h0,    0, 2'd2, 3'd4, 16'd0, 4'b0, 0, "R13 stop");
        step(0,1,0,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd0, 4'b0, 0, "R13 free change");
        step(0,1,1,0,1, 4'h0,    0, 2'd2, 3'd4, 16'd1, 4'b0, 0, "R13 complete");
        step(0,0,0,0,0, 4'hF,    0, 2'd3, 3'd4, 16'd1, 4'b0, 0, "R13 turn");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL queue: got %0d left exp 0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule